// File: doc/BRIEF.md
# Transmit Event Status Register

This block holds a 16-bit word that tells the host how the most recent frame transmission ended. The transmit engine sends it one-cycle pulses: a frame has finished, carrier was lost, the SQE test failed, a late collision occurred, the jabber timer expired, a collision occurred, or the sixteenth collision occurred. The block latches each pulse into its own bit of the word and counts collisions in a 4-bit field. The low six bits always carry a fixed identifier, so software can tell which register it is reading.

The host reads the word through a one-cycle read strobe. The read returns the current word and clears every event bit in the same cycle. A 16-bit enable word from a separate transmit configuration register has one enable at the same position as each event bit. The interrupt output is a level: it stays high while any enabled event is pending and falls once a read has cleared the word.

Top module: `tx_event_status_reg`

## Requirements
- R1: Bits 5..0 of the read word are always the identifier 6'b001000, with the LSB at bit 0.
- R2: After reset the word reads 16'h0008 and `irq_o` is low.
- R3: A pulse on `carrier_lost_i`, `sqe_fail_i`, `late_coll_i`, `jabber_i` or `coll_limit_i` sets bit 6, 7, 9, 10 or 15 respectively, one cycle later. The bit stays set until a read.
- R4: A cycle with `rd_i` high returns the current word on `rd_data_o` and clears bits 15..6 at the next clock edge.
- R5: On a `frame_done_i` pulse, bit 8 (transmit OK) is set only if no jabber, late-collision or collision-limit pulse arrived since the previous `frame_done_i`, counting the done cycle itself.
- R6: Bits 14..11 (bit 11 is the LSB) count the `coll_i` pulses since the last read.
- R7: The collision count stays at 15 once it reaches 15, rather than wrapping.
- R8: An event pulse that arrives in the same cycle as a read does not appear in that read's data. It is present in the word after the clear, and the next read returns it.
- R9: `irq_o` is high whenever any of bits 6, 7, 8, 9, 10 or 15 is set together with the enable bit at the same position of `irq_en_i`.
- R10: Enable bit 11 raises `irq_o` whenever the collision count is nonzero. Enable bits 14..12 and 5..0 have no effect.
- R11: After a read in a cycle with no new events, `irq_o` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released through an internal synchronizer |
| carrier_lost_i | input | 1 | Carrier-loss event pulse |
| sqe_fail_i | input | 1 | SQE test failure pulse |
| frame_done_i | input | 1 | End of a transmission attempt |
| late_coll_i | input | 1 | Out-of-window collision pulse |
| jabber_i | input | 1 | Jabber termination pulse |
| coll_i | input | 1 | One pulse for each collision |
| coll_limit_i | input | 1 | Sixteenth-collision abort pulse |
| irq_en_i | input | 16 | Per-bit interrupt enables from the configuration register |
| rd_i | input | 1 | Host read strobe; the read clears the event bits |
| rd_data_o | output | 16 | Current status word |
| irq_o | output | 1 | Level interrupt |

## Verification
Two functions can act in the same clock edge: the host's clearing read and the arrival of new event pulses. The bench pulses an event, a collision or a frame completion in the very cycle that `rd_i` is high. The read data for that cycle must not show the new event. The word after the clear must hold only that event, and a second read must return it and leave the word empty. A similar collision of functions is a frame completion that arrives together with a fatal pulse: transmit OK must stay clear.

// File: rtl/tx_evt_pkg.sv
package tx_evt_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned ID_W     = 6;
  localparam logic [ID_W-1:0] REG_ID = 6'b001000;
  localparam int unsigned CNT_W    = 4;
  localparam int unsigned NFLAG    = 6;

  // bit positions in the status word
  localparam int unsigned B_CARRIER = 6;
  localparam int unsigned B_SQE     = 7;
  localparam int unsigned B_OK      = 8;
  localparam int unsigned B_LATE    = 9;
  localparam int unsigned B_JABBER  = 10;
  localparam int unsigned B_CNT_LO  = 11;
  localparam int unsigned B_LIMIT   = 15;

  // flag bank index order
  localparam int unsigned F_CARRIER = 0;
  localparam int unsigned F_SQE     = 1;
  localparam int unsigned F_OK      = 2;
  localparam int unsigned F_LATE    = 3;
  localparam int unsigned F_JABBER  = 4;
  localparam int unsigned F_LIMIT   = 5;

  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/tx_evt_flag_bank.sv
module tx_evt_flag_bank #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q;
  logic [N-1:0] q_d;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_comb begin
      if (clr_i) q_d[g] = set_i[g];
      else       q_d[g] = q_q[g] | set_i[g];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_q[g] <= 1'b0;
      else if (clr_i || set_i[g]) q_q[g] <= q_d[g];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/tx_evt_coll_cnt.sv
module tx_evt_coll_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] cnt_q;
  logic [W-1:0] base;
  logic [W-1:0] cnt_d;
  logic         en;

  always_comb begin
    base  = clr_i ? '0 : cnt_q;
    cnt_d = base;
    if (inc_i && (base != MAX)) cnt_d = base + 1'b1;
    en = clr_i | inc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (en)  cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tx_evt_irq.sv
module tx_evt_irq
  import tx_evt_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              irq_o
);
  localparam logic [WORD_W-1:0] FLAG_MASK =
    (WORD_W'(1) << B_CARRIER) | (WORD_W'(1) << B_SQE) | (WORD_W'(1) << B_OK) |
    (WORD_W'(1) << B_LATE) | (WORD_W'(1) << B_JABBER) | (WORD_W'(1) << B_LIMIT);

  logic flag_hit;
  logic coll_hit;

  always_comb begin
    flag_hit = |(word_i & en_i & FLAG_MASK);
    coll_hit = en_i[B_CNT_LO] & (|cnt_i);
    irq_o    = flag_hit | coll_hit;
  end
endmodule

// File: rtl/tx_event_status_reg.sv
module tx_event_status_reg
  import tx_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              carrier_lost_i,
  input  logic              sqe_fail_i,
  input  logic              frame_done_i,
  input  logic              late_coll_i,
  input  logic              jabber_i,
  input  logic              coll_i,
  input  logic              coll_limit_i,
  input  logic [WORD_W-1:0] irq_en_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  // reset synchronizer: asserts at once, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // per-frame fatal tracking for the transmit OK decision
  logic fatal_now;
  logic fatal_q;
  logic fatal_d;
  logic ok_set;

  always_comb begin
    fatal_now = jabber_i | late_coll_i | coll_limit_i;
    ok_set    = frame_done_i & ~fatal_q & ~fatal_now;
    fatal_d   = frame_done_i ? 1'b0 : (fatal_q | fatal_now);
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) fatal_q <= 1'b0;
    else if (frame_done_i || fatal_now) fatal_q <= fatal_d;
  end

  flag_vec_t flag_set;
  flag_vec_t flag_q;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    flag_set            = '0;
    flag_set[F_CARRIER] = carrier_lost_i;
    flag_set[F_SQE]     = sqe_fail_i;
    flag_set[F_OK]      = ok_set;
    flag_set[F_LATE]    = late_coll_i;
    flag_set[F_JABBER]  = jabber_i;
    flag_set[F_LIMIT]   = coll_limit_i;
  end

  tx_evt_flag_bank #(.N(NFLAG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .set_i  (flag_set),
    .clr_i  (rd_i),
    .q_o    (flag_q)
  );

  tx_evt_coll_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .inc_i  (coll_i),
    .clr_i  (rd_i),
    .cnt_o  (cnt)
  );

  logic [WORD_W-1:0] word;

  always_comb begin
    word                           = '0;
    word[ID_W-1:0]                 = REG_ID;
    word[B_CARRIER]                = flag_q[F_CARRIER];
    word[B_SQE]                    = flag_q[F_SQE];
    word[B_OK]                     = flag_q[F_OK];
    word[B_LATE]                   = flag_q[F_LATE];
    word[B_JABBER]                 = flag_q[F_JABBER];
    word[B_CNT_LO +: CNT_W]        = cnt;
    word[B_LIMIT]                  = flag_q[F_LIMIT];
  end

  tx_evt_irq u_irq (
    .word_i (word),
    .en_i   (irq_en_i),
    .cnt_i  (cnt),
    .irq_o  (irq_o)
  );

  assign rd_data_o = word;
endmodule

// File: rtl/tx_event_status_reg_chk.sv
module tx_event_status_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        carrier_lost_i,
  input logic        sqe_fail_i,
  input logic        frame_done_i,
  input logic        late_coll_i,
  input logic        jabber_i,
  input logic        coll_i,
  input logic        coll_limit_i,
  input logic        rd_i,
  input logic [15:0] rd_data_o,
  input logic        irq_o
);
  logic quiet;
  assign quiet = !(carrier_lost_i | sqe_fail_i | frame_done_i | late_coll_i |
                   jabber_i | coll_i | coll_limit_i);

  p_id_const_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[5:0] == 6'b001000);

  p_clear_on_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && quiet) |=> (rd_data_o[15:6] == 10'd0));

  p_ok_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && frame_done_i && (jabber_i || late_coll_i || coll_limit_i)) |=> !rd_data_o[8]);

  p_cnt_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[14:11] == 4'hF && !rd_i) |=> (rd_data_o[14:11] == 4'hF));

  p_kept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && jabber_i) |=> rd_data_o[10]);

  p_irq_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && quiet) |=> !irq_o);
endmodule

bind tx_event_status_reg tx_event_status_reg_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .carrier_lost_i (carrier_lost_i),
  .sqe_fail_i     (sqe_fail_i),
  .frame_done_i   (frame_done_i),
  .late_coll_i    (late_coll_i),
  .jabber_i       (jabber_i),
  .coll_i         (coll_i),
  .coll_limit_i   (coll_limit_i),
  .rd_i           (rd_i),
  .rd_data_o      (rd_data_o),
  .irq_o          (irq_o)
);

// File: tb/tb_tx_event_status_reg.sv
module tb_tx_event_status_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        carrier_lost_i, sqe_fail_i, frame_done_i, late_coll_i;
  logic        jabber_i, coll_i, coll_limit_i, rd_i;
  logic [15:0] irq_en_i;
  logic [15:0] rd_data_o;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  tx_event_status_reg dut (.*);

  // event select bits: 0 carrier, 1 sqe, 2 done, 3 late, 4 jabber, 5 coll, 6 limit
  task automatic set_ev(input logic [6:0] e);
    carrier_lost_i = e[0]; sqe_fail_i = e[1]; frame_done_i = e[2];
    late_coll_i = e[3]; jabber_i = e[4]; coll_i = e[5]; coll_limit_i = e[6];
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pulse events for one cycle (no read)
  task automatic pulse(input logic [6:0] e);
    @(negedge clk_i); set_ev(e);
    @(negedge clk_i); set_ev(7'd0);
  endtask

  // read; optional events in the same cycle; returns data seen during the read
  task automatic do_read(input logic [6:0] e, output logic [15:0] data);
    @(negedge clk_i); set_ev(e); rd_i = 1'b1;
    #1 data = rd_data_o;
    @(negedge clk_i); set_ev(7'd0); rd_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R2 reset word", rd_data_o, 16'h0008);
    chk("R2 reset irq", {15'd0, irq_o}, 16'd0);
    chk("R1 id bits", {10'd0, rd_data_o[5:0]}, 16'h0008);
  endtask

  task automatic t_flags;
    logic [15:0] d;
    pulse(7'b0000001); chk("R3 carrier bit6", rd_data_o, 16'h0048);
    pulse(7'b0000010); chk("R3 sqe bit7", rd_data_o, 16'h00C8);
    pulse(7'b0001000); chk("R3 late bit9", rd_data_o, 16'h02C8);
    pulse(7'b0010000); chk("R3 jabber bit10", rd_data_o, 16'h06C8);
    pulse(7'b1000000); chk("R3 limit bit15", rd_data_o, 16'h86C8);
    do_read(7'd0, d);
    chk("R4 read returns word", d, 16'h86C8);
    chk("R4 cleared after read", rd_data_o, 16'h0008);
    pulse(7'b0000100); // close that frame
    do_read(7'd0, d);
  endtask

  task automatic t_ok;
    logic [15:0] d;
    pulse(7'b0000100);
    chk("R5 ok clean frame", rd_data_o, 16'h0108);
    do_read(7'd0, d);
    pulse(7'b0010000); pulse(7'b0000100);
    chk("R5 ok blocked by earlier jabber", rd_data_o, 16'h0408);
    do_read(7'd0, d);
    pulse(7'b0001100);
    chk("R5 ok blocked by same-cycle late", rd_data_o, 16'h0208);
    do_read(7'd0, d);
    pulse(7'b0000010); pulse(7'b0000100);
    chk("R5 ok not blocked by sqe", rd_data_o, 16'h0188);
    do_read(7'd0, d);
  endtask

  task automatic t_count;
    logic [15:0] d;
    for (int i = 0; i < 3; i++) pulse(7'b0100000);
    chk("R6 count three", rd_data_o, 16'h1808);
    for (int i = 0; i < 14; i++) pulse(7'b0100000);
    chk("R7 count saturates", rd_data_o, 16'h7808);
    do_read(7'd0, d);
    chk("R6 count cleared", rd_data_o, 16'h0008);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    pulse(7'b0000001);
    do_read(7'b0110000, d);
    chk("R8 read data excludes new", d, 16'h0048);
    chk("R8 new events kept", rd_data_o, 16'h0C08);
    do_read(7'd0, d);
    chk("R8 next read returns kept", d, 16'h0C08);
    chk("R8 empty after second read", rd_data_o, 16'h0008);
    pulse(7'b0000100);
    do_read(7'd0, d);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    irq_en_i = 16'h7000;
    pulse(7'b0100000);
    chk("R10 enables 14..12 ignored", {15'd0, irq_o}, 16'd0);
    irq_en_i = 16'h0800;
    #1 chk("R10 any-collision enable", {15'd0, irq_o}, 16'd1);
    do_read(7'd0, d);
    chk("R11 irq drops after read", {15'd0, irq_o}, 16'd0);
    irq_en_i = 16'h0080;
    pulse(7'b0000001);
    chk("R9 unmatched enable", {15'd0, irq_o}, 16'd0);
    pulse(7'b0000010);
    chk("R9 matched enable sqe", {15'd0, irq_o}, 16'd1);
    do_read(7'd0, d);
    irq_en_i = 16'h803F;
    pulse(7'b1000000);
    chk("R9 limit enable", {15'd0, irq_o}, 16'd1);
    do_read(7'd0, d);
    chk("R11 irq low after clear", {15'd0, irq_o}, 16'd0);
    pulse(7'b0000100);
    do_read(7'd0, d);
    irq_en_i = 16'h0000;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; rd_i = 1'b0; irq_en_i = 16'h0000; set_ev(7'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset;
    t_flags;
    t_ok;
    t_count;
    t_collide;
    t_irq;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule